// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block performs the arithmetic and logic step of a 32-bit processor's data-processing instructions. For each operation it takes the instruction word, the value of the first-operand register, the instruction's own address, a second operand already shaped by the barrel shifter, the shifter's carry-out, and the current and saved condition flags. It returns the result, a write-enable for the destination register, the condition flags that should follow the operation, and two indications for the caller: one that the saved status must be restored, and one that the pipeline must be flushed because the program counter is being written.

Operations enter through a valid/ready stream and leave through a second valid/ready stream after one register stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. So a stalled consumer holds off the producer with no extra cycle of delay, and a held result stays exactly as it is until it is taken.

Decoding is fixed to the 32-bit instruction layout. Bits 24:21 give the opcode, bit 20 is the set-flags bit, bits 19:16 name the first-operand register, and bits 15:12 name the destination. Register 15 is the program counter.

Top module: `dp_flag_alu`

## Requirements
- R1: Logical opcodes produce these results with the destination written: 0 AND gives op1&op2, 1 EOR gives op1^op2, 12 ORR gives op1|op2, 13 MOV gives op2, 14 BIC gives op1&~op2, and 15 MVN gives ~op2.
- R2: Arithmetic opcodes produce these results with the destination written: 2 SUB gives op1-op2, 3 RSB gives op2-op1, 4 ADD gives op1+op2, 5 ADC gives op1+op2+C, 6 SBC gives op1-(op2+1-C), and 7 RSC gives op2-(op1+1-C). All are taken modulo 2^32.
- R3: Test opcodes never write the destination and never flush. These are 8 TST (AND), 9 TEQ (XOR), 10 CMP (subtract) and 11 CMN (add). `out_result` still carries the computed value.
- R4: When flags are set, arithmetic opcodes take C from the adder carry-out and V from signed overflow. For subtraction, C is 1 when no borrow occurs.
- R5: When flags are set, logical and test-logical opcodes take C from `in_shc` and keep V from `in_nzcv`.
- R6: Flags are packed as {N,Z,C,V} in bits 3..0. With bit 20 set, N is result bit 31 and Z is 1 when the result is zero. With bit 20 clear, `out_nzcv` equals `in_nzcv`.
- R7: When bits 19:16 equal 15, op1 is `in_pc`+8. It is `in_pc`+12 when `in_shift_by_reg` is 1. Otherwise op1 is `in_rn_val`.
- R8: A non-test opcode with bit 20 set and destination 15 outputs `in_saved_nzcv` as the flags and raises `out_restore`.
- R9: `out_flush` is 1 exactly when the destination is written and bits 15:12 equal 15.
- R10: A result is presented on the cycle after its operation is accepted. While `out_valid` is high and `out_ready` is low, all outputs hold and `in_ready` is low. Results leave in the order they were accepted.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| in_rn_val | input | 32 | Value of the first-operand register |
| in_op2 | input | 32 | Shifted second operand |
| in_shift_by_reg | input | 1 | Shift amount came from a register |
| in_shc | input | 1 | Shifter carry-out |
| in_nzcv | input | 4 | Current flags {N,Z,C,V} |
| in_saved_nzcv | input | 4 | Saved status flags {N,Z,C,V} |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Computed value |
| out_wr_en | output | 1 | Write the destination register |
| out_nzcv | output | 4 | Flags after the operation |
| out_restore | output | 1 | Saved status replaces current status |
| out_flush | output | 1 | Program counter written; refill pipeline |

## Verification
Every result, write-enable, flag and indication is due one cycle after the edge that accepts its operation. After that it is held for as long as the consumer stalls. The driver records the expected item when it sees `in_ready` high before the accepting edge. The monitor compares only at falling edges where `out_valid` and its own `out_ready` are both high, which are the cycles just before the result is taken. The monitor toggles `out_ready` at random to stretch those holds, so the one-cycle latency and the hold behaviour are both exercised.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  localparam int OPC_LSB   = 21;
  localparam int OPC_W     = 4;
  localparam int SFLAG_BIT = 20;
  localparam int RN_LSB    = 16;
  localparam int RD_LSB    = 12;
  localparam int REG_W     = 4;
  localparam logic [REG_W-1:0] PC_IDX = 4'd15;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic logic op_is_test(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction
endpackage

// File: rtl/dpalu_opsel.sv
module dpalu_opsel #(
  parameter int DW = 32,
  parameter int REG_W = 4,
  parameter int PC_NEAR = 8,
  parameter int PC_FAR = 12
) (
  input  logic [REG_W-1:0] rn_idx,
  input  logic [DW-1:0]    rn_val,
  input  logic [DW-1:0]    pc,
  input  logic             shift_by_reg,
  output logic [DW-1:0]    op1
);
  localparam logic [REG_W-1:0] PC_REG = {REG_W{1'b1}};
  localparam logic [DW-1:0] NEAR = DW'(PC_NEAR);
  localparam logic [DW-1:0] FAR  = DW'(PC_FAR);

  always_comb begin
    if (rn_idx == PC_REG) op1 = pc + (shift_by_reg ? FAR : NEAR);
    else                  op1 = rn_val;
  end
endmodule

// File: rtl/dpalu_exec.sv
module dpalu_exec
  import dpalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic          set_flags,
  input  logic          rd_is_pc,
  input  logic [DW-1:0] op1,
  input  logic [DW-1:0] op2,
  input  logic          shc,
  input  logic [3:0]    cur_nzcv,
  input  logic [3:0]    saved_nzcv,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [3:0]    nzcv,
  output logic          restore,
  output logic          flush
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] add_a, add_b;
  logic          add_cin;
  logic [DW:0]   sum;
  logic          ovf;
  logic          is_test, is_arith;

  assign is_test  = op_is_test(op);
  assign is_arith = op_is_arith(op);

  always_comb begin
    add_a = op1;
    add_b = op2;
    add_cin = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin add_b = ~op2; add_cin = 1'b1; end
      OP_RSB:         begin add_a = op2; add_b = ~op1; add_cin = 1'b1; end
      OP_ADC:         add_cin = cur_nzcv[FLAG_C];
      OP_SBC:         begin add_b = ~op2; add_cin = cur_nzcv[FLAG_C]; end
      OP_RSC:         begin add_a = op2; add_b = ~op1; add_cin = cur_nzcv[FLAG_C]; end
      default:        ;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, add_cin};
  assign ovf = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: result = op1 & op2;
      OP_EOR, OP_TEQ: result = op1 ^ op2;
      OP_ORR:         result = op1 | op2;
      OP_MOV:         result = op2;
      OP_BIC:         result = op1 & ~op2;
      OP_MVN:         result = ~op2;
      default:        result = sum[DW-1:0];
    endcase
  end

  assign wr_en   = !is_test;
  assign flush   = wr_en && rd_is_pc;
  assign restore = set_flags && wr_en && rd_is_pc;

  always_comb begin
    nzcv = cur_nzcv;
    if (restore) begin
      nzcv = saved_nzcv;
    end else if (set_flags) begin
      nzcv[FLAG_N] = result[MSB];
      nzcv[FLAG_Z] = (result == '0);
      nzcv[FLAG_C] = is_arith ? sum[DW] : shc;
      nzcv[FLAG_V] = is_arith ? ovf : cur_nzcv[FLAG_V];
    end
  end

  always_comb begin
    if (!set_flags) a_r6_flags_pass: assert (nzcv == cur_nzcv);
  end
endmodule

// File: rtl/dpalu_stage.sv
module dpalu_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] hold;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign out_data  = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        full <= 1'b0;
    else if (in_ready) full <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) hold <= in_data;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/dp_flag_alu.sv
module dp_flag_alu
  import dpalu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_insn,
  input  logic [DW-1:0] in_pc,
  input  logic [DW-1:0] in_rn_val,
  input  logic [DW-1:0] in_op2,
  input  logic          in_shift_by_reg,
  input  logic          in_shc,
  input  logic [3:0]    in_nzcv,
  input  logic [3:0]    in_saved_nzcv,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_wr_en,
  output logic [3:0]    out_nzcv,
  output logic          out_restore,
  output logic          out_flush
);
  localparam int PW = DW + 7;

  alu_op_e          op;
  logic             sflag;
  logic [REG_W-1:0] rn_idx, rd_idx;
  logic [DW-1:0]    op1, res;
  logic             wr, rst_f, fl;
  logic [3:0]       flags;
  logic [PW-1:0]    pay_in, pay_out;

  assign op     = alu_op_e'(in_insn[OPC_LSB +: OPC_W]);
  assign sflag  = in_insn[SFLAG_BIT];
  assign rn_idx = in_insn[RN_LSB +: REG_W];
  assign rd_idx = in_insn[RD_LSB +: REG_W];

  dpalu_opsel #(.DW(DW), .REG_W(REG_W)) u_opsel (
    .rn_idx(rn_idx), .rn_val(in_rn_val), .pc(in_pc),
    .shift_by_reg(in_shift_by_reg), .op1(op1)
  );

  dpalu_exec #(.DW(DW)) u_exec (
    .op(op), .set_flags(sflag), .rd_is_pc(rd_idx == PC_IDX),
    .op1(op1), .op2(in_op2), .shc(in_shc),
    .cur_nzcv(in_nzcv), .saved_nzcv(in_saved_nzcv),
    .result(res), .wr_en(wr), .nzcv(flags), .restore(rst_f), .flush(fl)
  );

  assign pay_in = {res, wr, flags, rst_f, fl};

  dpalu_stage #(.W(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign {out_result, out_wr_en, out_nzcv, out_restore, out_flush} = pay_out;

  logic accept;
  assign accept = in_valid && in_ready;

  a_r3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_insn[OPC_LSB+3 -: 2] == 2'b10) |=> (out_valid && !out_wr_en && !out_flush));

  a_r5_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sflag && !op_is_arith(op) && !(wr && rd_idx == PC_IDX))
      |=> (out_nzcv[FLAG_C] == $past(in_shc) && out_nzcv[FLAG_V] == $past(in_nzcv[FLAG_V])));

  a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_restore) |-> (out_flush && out_wr_en));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_is_test(op) && rd_idx == PC_IDX) |=> out_flush);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/tb_dp_flag_alu.sv
module tb_dp_flag_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_insn = '0, in_pc = '0, in_rn_val = '0, in_op2 = '0;
  logic        in_shift_by_reg = 1'b0, in_shc = 1'b0;
  logic [3:0]  in_nzcv = '0, in_saved_nzcv = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_wr_en, out_restore, out_flush;
  logic [3:0]  out_nzcv;

  dp_flag_alu dut (.*);

  typedef struct {
    logic [31:0] res; logic wr; logic [3:0] f; logic rs; logic fl; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit stall_on = 1'b0;

  function automatic exp_t model(logic [3:0] op, logic s, logic [3:0] rn, logic [3:0] rd,
      logic [31:0] rv, logic [31:0] pc, logic sbr, logic [31:0] b, logic shc,
      logic [3:0] cur, logic [3:0] sav, string tag);
    exp_t e;
    logic [31:0] a, x, y, r;
    logic cin, c, v, arith;
    longint sl;
    logic [32:0] sub;
    a = (rn == 4'd15) ? pc + (sbr ? 32'd12 : 32'd8) : rv;
    cin = cur[1];
    c = shc; v = cur[0]; arith = 1'b1;
    x = a; y = b;
    if (op == 4'd3 || op == 4'd7) begin x = b; y = a; end
    case (op)
      4'd0, 4'd8:  begin r = a & b; arith = 0; end
      4'd1, 4'd9:  begin r = a ^ b; arith = 0; end
      4'd12:       begin r = a | b; arith = 0; end
      4'd13:       begin r = b; arith = 0; end
      4'd14:       begin r = a & ~b; arith = 0; end
      4'd15:       begin r = ~b; arith = 0; end
      4'd4, 4'd11, 4'd5: begin
        r = x + y + ((op == 4'd5) ? {31'd0, cin} : 32'd0);
        c = ({1'b0, x} + {1'b0, y} + ((op == 4'd5) ? {32'd0, cin} : 33'd0)) > 33'hFFFFFFFF;
        sl = longint'($signed(x)) + longint'($signed(y)) + ((op == 4'd5) ? longint'(cin) : 0);
      end
      default: begin
        sub = {1'b0, y} + ((op == 4'd6 || op == 4'd7) ? {32'd0, ~cin} : 33'd0);
        r = x - sub[31:0];
        c = {1'b0, x} >= sub;
        sl = longint'($signed(x)) - longint'($signed(y)) - ((op == 4'd6 || op == 4'd7) ? longint'(~cin) : 0);
      end
    endcase
    if (arith) v = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
    e.res = r; e.wr = !(op >= 4'd8 && op <= 4'd11);
    e.fl = e.wr && rd == 4'd15;
    e.rs = s && e.fl;
    if (!s) e.f = cur;
    else if (e.rs) e.f = sav;
    else e.f = {r[31], r == 32'd0, c, v};
    e.tag = tag;
    return e;
  endfunction

  task automatic send(logic [3:0] op, logic s, logic [3:0] rn, logic [3:0] rd,
      logic [31:0] rv, logic [31:0] pc, logic sbr, logic [31:0] b, logic shc,
      logic [3:0] cur, logic [3:0] sav, string tag);
    @(negedge clk); #1;
    in_insn = {7'b1110000, op, s, rn, rd, 12'h000};
    in_rn_val = rv; in_pc = pc; in_shift_by_reg = sbr; in_op2 = b;
    in_shc = shc; in_nzcv = cur; in_saved_nzcv = sav; in_valid = 1'b1;
    while (!in_ready) begin @(negedge clk); #1; end
    q.push_back(model(op, s, rn, rd, rv, pc, sbr, b, shc, cur, sav, tag));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_on ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (rst_n && out_valid && out_ready) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result act=%h exp=none", out_result);
        end else begin
          e = q.pop_front();
          if (out_result !== e.res || out_wr_en !== e.wr || out_nzcv !== e.f ||
              out_restore !== e.rs || out_flush !== e.fl) begin
            errors++;
            $display("FAIL %s act res=%h wr=%b f=%b rs=%b fl=%b exp res=%h wr=%b f=%b rs=%b fl=%b",
              e.tag, out_result, out_wr_en, out_nzcv, out_restore, out_flush,
              e.res, e.wr, e.f, e.rs, e.fl);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 act v=%b r=%b exp v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    // R1 logical results
    send(4'd0,  0, 4'd1, 4'd2, 32'hF0F0_1234, 0, 0, 32'h0FF0_FF00, 0, 4'b0000, 0, "R1");
    send(4'd1,  0, 4'd1, 4'd2, 32'hAAAA_5555, 0, 0, 32'hFFFF_0000, 0, 4'b1010, 0, "R1");
    send(4'd12, 0, 4'd1, 4'd2, 32'h1200_0034, 0, 0, 32'h0056_7800, 0, 4'b0101, 0, "R1");
    send(4'd13, 0, 4'd1, 4'd2, 32'h0, 0, 0, 32'hDEAD_BEEF, 0, 4'b0000, 0, "R1");
    send(4'd14, 0, 4'd1, 4'd2, 32'hFFFF_FFFF, 0, 0, 32'h0000_FF00, 0, 4'b0000, 0, "R1");
    send(4'd15, 0, 4'd1, 4'd2, 32'h0, 0, 0, 32'h1234_5678, 0, 4'b0000, 0, "R1");
    // R2 arithmetic results
    send(4'd2, 0, 4'd3, 4'd4, 32'd100, 0, 0, 32'd30, 0, 4'b0000, 0, "R2");
    send(4'd3, 0, 4'd3, 4'd4, 32'd30, 0, 0, 32'd100, 0, 4'b0000, 0, "R2");
    send(4'd4, 0, 4'd3, 4'd4, 32'hFFFF_FFFF, 0, 0, 32'd2, 0, 4'b0000, 0, "R2");
    send(4'd5, 0, 4'd3, 4'd4, 32'd7, 0, 0, 32'd8, 0, 4'b0010, 0, "R2");
    send(4'd6, 0, 4'd3, 4'd4, 32'd50, 0, 0, 32'd20, 0, 4'b0000, 0, "R2");
    send(4'd7, 0, 4'd3, 4'd4, 32'd20, 0, 0, 32'd50, 0, 4'b0010, 0, "R2");
    // R3 test opcodes, including destination field 15
    send(4'd8,  1, 4'd1, 4'd15, 32'hF0, 0, 0, 32'h0F, 1, 4'b0001, 4'b1111, "R3");
    send(4'd9,  1, 4'd1, 4'd0,  32'h55, 0, 0, 32'h55, 0, 4'b0000, 0, "R3");
    send(4'd10, 1, 4'd1, 4'd15, 32'd9, 0, 0, 32'd9, 0, 4'b0000, 4'b1111, "R3");
    send(4'd11, 1, 4'd1, 4'd0,  32'h8000_0000, 0, 0, 32'h8000_0000, 0, 4'b0000, 0, "R3");
    // R4 arithmetic flags
    send(4'd4, 1, 4'd1, 4'd2, 32'h7FFF_FFFF, 0, 0, 32'd1, 0, 4'b0000, 0, "R4");
    send(4'd2, 1, 4'd1, 4'd2, 32'd0, 0, 0, 32'd1, 0, 4'b0010, 0, "R4");
    send(4'd6, 1, 4'd1, 4'd2, 32'd5, 0, 0, 32'd4, 0, 4'b0000, 0, "R4");
    send(4'd5, 1, 4'd1, 4'd2, 32'hFFFF_FFFF, 0, 0, 32'd0, 0, 4'b0010, 0, "R4");
    // R5 logical flags
    send(4'd13, 1, 4'd1, 4'd2, 32'd0, 0, 0, 32'h8000_0000, 1, 4'b0001, 0, "R5");
    send(4'd0,  1, 4'd1, 4'd2, 32'hF, 0, 0, 32'hF0, 0, 4'b0011, 0, "R5");
    // R6 flags pass through when bit 20 is clear
    send(4'd2, 0, 4'd1, 4'd2, 32'd0, 0, 0, 32'd1, 1, 4'b0110, 0, "R6");
    // R7 program counter as first operand
    send(4'd4, 0, 4'd15, 4'd2, 32'hFFFF, 32'h0000_1000, 0, 32'd0, 0, 4'b0000, 0, "R7");
    send(4'd4, 0, 4'd15, 4'd2, 32'hFFFF, 32'h0000_1000, 1, 32'd0, 0, 4'b0000, 0, "R7");
    // R8 restore of saved flags, R9 flush
    send(4'd4,  1, 4'd1, 4'd15, 32'd1, 0, 0, 32'd1, 0, 4'b0000, 4'b1010, "R8");
    send(4'd13, 0, 4'd1, 4'd15, 32'd0, 0, 0, 32'h0000_2000, 0, 4'b0100, 4'b1111, "R9");
    // R10 random traffic under back-pressure
    stall_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      string tg;
      op = 4'($urandom_range(0, 15));
      tg = (op >= 4'd8 && op <= 4'd11) ? "R3" : ((op >= 4'd2 && op <= 4'd7) ? "R2" : "R1");
      if (i % 3 == 0) tg = "R10";
      send(op, 1'($urandom), 4'($urandom), 4'($urandom), $urandom, $urandom & 32'hFFFF_FFFC,
           1'($urandom), $urandom, 1'($urandom), 4'($urandom), 4'($urandom), tg);
    end
    stall_on = 1'b0;
    repeat (20) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 act pending=%0d exp pending=0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule